// File: doc/BRIEF.md
# Three-Block Rotating Commit Controller

This controller keeps one record in three flash blocks, called X, Y and Z, so that an update either completes or leaves no trace. Each block has one control flag. A block holds the valid record when its own flag is blank and the flag of the block before it in the ring X→Y→Z→X is programmed. The flag of the third block does not matter. An erase that is cut short therefore never confuses the decode: only the other two flags decide which block is current.

After reset the controller reads the three flags through its flash command port and resolves the current block. On an update request it erases the block after the current one. It erases that block even if it already reads blank. It then streams the record words into that block from the data source. Last, it programs the flag of the old current block. That one flag program is the commit. Every flash command stays asserted until the flash answers with a one-cycle done pulse.

The state machine has these states: `ST_RD_X`, `ST_RD_Y`, `ST_RD_Z` (flag reads), `ST_DECODE`, `ST_IDLE`, `ST_ERASE`, `ST_WRITE`, `ST_COMMIT` and `ST_FAULT`. The transitions are:
- each read state moves to the next read state on done, and `ST_RD_Z` moves to `ST_DECODE`;
- `ST_DECODE` moves to `ST_FAULT` on a bad pattern and to `ST_IDLE` otherwise;
- `ST_IDLE` moves to `ST_ERASE` on a request;
- `ST_ERASE` moves to `ST_WRITE` on done;
- `ST_WRITE` moves to `ST_COMMIT` on the done of the last word;
- `ST_COMMIT` moves to `ST_IDLE` on done;
- `ST_FAULT` is left only by reset.

Top module: `rot_commit_ctrl`

## Requirements
- R1: After reset the controller issues read-flag commands (`fl_cmd` = 3) to blocks 0, 1, 2 in that order, where 0 = X, 1 = Y and 2 = Z. It needs exactly one extra cycle after the done of the last read, and then `busy` falls.
- R2: A returned flag value of 1 means programmed. If exactly one block has its own flag blank and its predecessor's flag programmed (the predecessor of 0 is 2), `cur_blk` shows that block and `cur_valid` is 1.
- R3: If all three flags are blank, `cur_valid` is 0 and `cur_blk` is 2. The first update then writes block 0 and commits by programming the flag of block 2.
- R4: If all three flags are programmed, `err` rises and `busy` is 0.
- R5: Once `err` is set it stays set until reset. While it is set, update requests issue no flash command.
- R6: An update first erases (`fl_cmd` = 0) the block after `cur_blk`, even if that block is blank. It then writes words 0 to WORDS-1 (`fl_cmd` = 1), putting `src_data` on `fl_wdata` with the word number on `fl_idx`.
- R7: Only after the done of the last data write does the controller program the flag (`fl_cmd` = 2) of the old current block.
- R8: On the done of that flag program, `cur_blk` moves one step around the ring, `cur_valid` becomes 1 and `busy` falls. Repeated updates visit X→Y→Z→X.
- R9: A reset at any point before the flag program completes leaves the old block current at the next start-up.
- R10: An update request that arrives while `busy` is high is dropped and does not start a second update.
- R11: Once a flash command is asserted, its type, block and word number stay unchanged until its done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd_req | input | 1 | Update request, sampled in idle |
| busy | output | 1 | High from reset until idle, and during an update |
| fl_cmd_valid | output | 1 | A flash command is pending |
| fl_cmd | output | 2 | Command type: 0 erase, 1 program data, 2 program flag, 3 read flag |
| fl_blk | output | 2 | Target block: 0 X, 1 Y, 2 Z |
| fl_idx | output | IDX_W | Word number for a data program |
| fl_wdata | output | DATA_W | Word to program |
| fl_done | input | 1 | One-cycle completion pulse for the pending command |
| fl_flag_rd | input | 1 | Flag value that comes with the done of a read (1 = programmed) |
| src_data | input | DATA_W | Record word selected by `fl_idx` |
| cur_blk | output | 2 | Current block index |
| cur_valid | output | 1 | A committed record exists |
| err | output | 1 | Flag pattern is corrupt |

## Verification
The bench goes through all eight flag patterns. A decoder that reversed the predecessor direction would pick the wrong block, and one that accepted all-programmed flags would hide corruption. From each good pattern the bench runs three updates in a row. This catches a design that writes to the current block, commits the wrong flag or skips the erase of a blank block. The bench also resets the controller partway through the data writes and again just before the commit. A design that moved `cur_blk` early, or that committed before the last write, would then come back pointing at a half-written block. The bench also sends a request while `busy` is high, which exposes a design that queues it or restarts.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

    typedef enum logic [1:0] {
        CMD_ERASE = 2'd0,
        CMD_DATA  = 2'd1,
        CMD_FLAG  = 2'd2,
        CMD_READ  = 2'd3
    } fl_cmd_e;

    typedef enum logic [3:0] {
        ST_RD_X,
        ST_RD_Y,
        ST_RD_Z,
        ST_DECODE,
        ST_IDLE,
        ST_ERASE,
        ST_WRITE,
        ST_COMMIT,
        ST_FAULT
    } state_e;

    localparam int unsigned NUM_BLKS = 3;

    function automatic logic [1:0] blk_next(input logic [1:0] b);
        return (b == 2'd2) ? 2'd0 : b + 2'd1;
    endfunction

endpackage

// File: rtl/rcc_flag_decode.sv
module rcc_flag_decode
    import rcc_pkg::*;
(
    input  logic [NUM_BLKS-1:0] flags,
    output logic                hit,
    output logic [1:0]          hit_blk,
    output logic                none_set,
    output logic                bad
);
    logic [NUM_BLKS-1:0] cand;

    for (genvar i = 0; i < NUM_BLKS; i++) begin : g_cand
        localparam int PREV = (i + NUM_BLKS - 1) % NUM_BLKS;
        assign cand[i] = !flags[i] && flags[PREV];
    end

    always_comb begin
        hit_blk = 2'd0;
        for (int i = 0; i < NUM_BLKS; i++) begin
            if (cand[i]) hit_blk = 2'(i);
        end
        hit      = ($countones(cand) == 1);
        none_set = (flags == '0);
        bad      = !none_set && !hit;
    end
endmodule

// File: rtl/rcc_word_seq.sv
module rcc_word_seq #(
    parameter int unsigned WORDS = 4,
    localparam int unsigned IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    output logic [IDX_W-1:0] idx,
    output logic             last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    idx <= '0;
        else if (clr)  idx <= '0;
        else if (step) idx <= idx + 1'b1;
    end

    assign last = (idx == IDX_W'(WORDS - 1));
endmodule

// File: rtl/rot_commit_ctrl.sv
module rot_commit_ctrl
    import rcc_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned WORDS  = 4,
    localparam int unsigned IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_req,
    output logic              busy,
    output logic              fl_cmd_valid,
    output logic [1:0]        fl_cmd,
    output logic [1:0]        fl_blk,
    output logic [IDX_W-1:0]  fl_idx,
    output logic [DATA_W-1:0] fl_wdata,
    input  logic              fl_done,
    input  logic              fl_flag_rd,
    input  logic [DATA_W-1:0] src_data,
    output logic [1:0]        cur_blk,
    output logic              cur_valid,
    output logic              err
);
    state_e              state, state_nx;
    logic [NUM_BLKS-1:0] flags_q;
    logic                dec_hit, dec_none, dec_bad, word_last;
    logic [1:0]          dec_blk;
    fl_cmd_e             cmd_c;

    rcc_flag_decode u_dec (
        .flags   (flags_q),
        .hit     (dec_hit),
        .hit_blk (dec_blk),
        .none_set(dec_none),
        .bad     (dec_bad)
    );

    rcc_word_seq #(.WORDS(WORDS)) u_seq (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state == ST_ERASE),
        .step (state == ST_WRITE && fl_done),
        .idx  (fl_idx),
        .last (word_last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RD_X;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RD_X:   if (fl_done) state_nx = ST_RD_Y;
            ST_RD_Y:   if (fl_done) state_nx = ST_RD_Z;
            ST_RD_Z:   if (fl_done) state_nx = ST_DECODE;
            ST_DECODE: state_nx = dec_bad ? ST_FAULT : ST_IDLE;
            ST_IDLE:   if (upd_req) state_nx = ST_ERASE;
            ST_ERASE:  if (fl_done) state_nx = ST_WRITE;
            ST_WRITE:  if (fl_done && word_last) state_nx = ST_COMMIT;
            ST_COMMIT: if (fl_done) state_nx = ST_IDLE;
            ST_FAULT:  state_nx = ST_FAULT;
            default:   state_nx = ST_FAULT;
        endcase
    end

    // outputs
    always_comb begin
        fl_cmd_valid = 1'b0;
        cmd_c        = CMD_READ;
        fl_blk       = 2'd0;
        busy         = 1'b1;
        unique case (state)
            ST_RD_X:   begin fl_cmd_valid = 1'b1; cmd_c = CMD_READ; fl_blk = 2'd0; end
            ST_RD_Y:   begin fl_cmd_valid = 1'b1; cmd_c = CMD_READ; fl_blk = 2'd1; end
            ST_RD_Z:   begin fl_cmd_valid = 1'b1; cmd_c = CMD_READ; fl_blk = 2'd2; end
            ST_DECODE: busy = 1'b1;
            ST_IDLE:   busy = 1'b0;
            ST_ERASE:  begin fl_cmd_valid = 1'b1; cmd_c = CMD_ERASE; fl_blk = blk_next(cur_blk); end
            ST_WRITE:  begin fl_cmd_valid = 1'b1; cmd_c = CMD_DATA;  fl_blk = blk_next(cur_blk); end
            ST_COMMIT: begin fl_cmd_valid = 1'b1; cmd_c = CMD_FLAG;  fl_blk = cur_blk; end
            ST_FAULT:  busy = 1'b0;
            default:   busy = 1'b0;
        endcase
        fl_cmd   = cmd_c;
        fl_wdata = src_data;
    end

    // flag capture and current-block tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q   <= '0;
            cur_blk   <= 2'd2;
            cur_valid <= 1'b0;
            err       <= 1'b0;
        end else begin
            if (fl_done && (state == ST_RD_X || state == ST_RD_Y || state == ST_RD_Z))
                flags_q[fl_blk] <= fl_flag_rd;
            if (state == ST_DECODE) begin
                cur_blk   <= dec_none ? 2'd2 : dec_blk;
                cur_valid <= dec_hit;
                err       <= dec_bad;
            end
            if (state == ST_COMMIT && fl_done) begin
                cur_blk   <= blk_next(cur_blk);
                cur_valid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rcc_checker.sv
module rcc_checker #(
    parameter int unsigned IDX_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fl_cmd_valid,
    input logic [1:0]       fl_cmd,
    input logic [1:0]       fl_blk,
    input logic [IDX_W-1:0] fl_idx,
    input logic             fl_done,
    input logic [1:0]       cur_blk,
    input logic             cur_valid,
    input logic             err
);
    function automatic logic [1:0] ring_step(input logic [1:0] b);
        return (b == 2'd2) ? 2'd0 : b + 2'd1;
    endfunction

    assert_blk_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cur_blk != 2'd3);

    assert_fault_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    assert_fault_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !fl_cmd_valid);

    assert_erase_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_cmd_valid && fl_cmd == 2'd0) |-> fl_blk == ring_step(cur_blk));

    assert_commit_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_cmd_valid && fl_cmd == 2'd2) |-> fl_blk == cur_blk);

    assert_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_cmd_valid && fl_cmd == 2'd2 && fl_done)
            |=> cur_valid && cur_blk == ring_step($past(cur_blk)));

    assert_cmd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_cmd_valid && !fl_done)
            |=> fl_cmd_valid && $stable(fl_cmd) && $stable(fl_blk) && $stable(fl_idx));
endmodule

bind rot_commit_ctrl rcc_checker #(.IDX_W(IDX_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .fl_cmd_valid(fl_cmd_valid),
    .fl_cmd      (fl_cmd),
    .fl_blk      (fl_blk),
    .fl_idx      (fl_idx),
    .fl_done     (fl_done),
    .cur_blk     (cur_blk),
    .cur_valid   (cur_valid),
    .err         (err)
);

// File: tb/rot_commit_ctrl_tb_top.sv
module rot_commit_ctrl_tb_top;
    localparam int DATA_W = 8;
    localparam int WORDS  = 4;
    localparam int IDX_W  = 2;
    localparam int LAT    = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              upd_req = 1'b0;
    logic              busy, fl_cmd_valid, fl_done, fl_flag_rd, cur_valid, err;
    logic [1:0]        fl_cmd, fl_blk, cur_blk;
    logic [IDX_W-1:0]  fl_idx;
    logic [DATA_W-1:0] fl_wdata, src_data;
    logic [7:0]        seed = 8'h00;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    assign src_data = seed ^ (8'(fl_idx) * 8'd37);

    rot_commit_ctrl #(.DATA_W(DATA_W), .WORDS(WORDS)) dut_i (
        .clk(clk), .rst_n(rst_n), .upd_req(upd_req), .busy(busy),
        .fl_cmd_valid(fl_cmd_valid), .fl_cmd(fl_cmd), .fl_blk(fl_blk),
        .fl_idx(fl_idx), .fl_wdata(fl_wdata), .fl_done(fl_done),
        .fl_flag_rd(fl_flag_rd), .src_data(src_data), .cur_blk(cur_blk),
        .cur_valid(cur_valid), .err(err)
    );

    // flash model: persists across controller reset
    logic       pl_en = 1'b0;
    logic [2:0] pl_flags = 3'b000;
    logic [2:0] mflag = 3'b000;
    logic [7:0] mem [3][WORDS];
    int         erase_cnt [3];
    int         ncmd = 0, ndata = 0, rd_n = 0, hold_bad = 0, cnt = 0;
    logic [1:0] rd_log [4];
    logic       have = 1'b0;
    logic [1:0] h_cmd, h_blk;
    logic [IDX_W-1:0] h_idx;

    initial begin
        fl_done = 1'b0; fl_flag_rd = 1'b0;
        for (int b = 0; b < 3; b++) begin
            erase_cnt[b] = 0;
            for (int w = 0; w < WORDS; w++) mem[b][w] = 8'h00;
        end
    end

    always @(posedge clk) begin
        if (pl_en) mflag <= pl_flags;
        if (!rst_n) begin
            fl_done <= 1'b0; cnt <= 0; rd_n <= 0; have <= 1'b0;
        end else if (fl_done) begin
            fl_done <= 1'b0; cnt <= 0; have <= 1'b0;
        end else if (fl_cmd_valid) begin
            if (have && (fl_cmd != h_cmd || fl_blk != h_blk || fl_idx != h_idx))
                hold_bad <= hold_bad + 1;
            have <= 1'b1; h_cmd <= fl_cmd; h_blk <= fl_blk; h_idx <= fl_idx;
            if (cnt == LAT) begin
                fl_done <= 1'b1;
                ncmd    <= ncmd + 1;
                case (fl_cmd)
                    2'd0: begin
                        erase_cnt[fl_blk] <= erase_cnt[fl_blk] + 1;
                        mflag[fl_blk] <= 1'b0;
                        for (int w = 0; w < WORDS; w++) mem[fl_blk][w] <= 8'hFF;
                    end
                    2'd1: begin
                        mem[fl_blk][fl_idx] <= mem[fl_blk][fl_idx] & fl_wdata;
                        ndata <= ndata + 1;
                    end
                    2'd2: mflag[fl_blk] <= 1'b1;
                    default: begin
                        fl_flag_rd <= mflag[fl_blk];
                        if (rd_n < 4) rd_log[rd_n] <= fl_blk;
                        rd_n <= rd_n + 1;
                    end
                endcase
            end else begin
                cnt <= cnt + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ring_next(input int b);
        return (b + 1) % 3;
    endfunction

    // reset the controller with given flags, wait for decode; returns busy cycles after last read
    task automatic start_up(input logic [2:0] f, output int extra);
        bit seen = 0;
        extra = 0;
        @(negedge clk);
        rst_n = 1'b0; pl_flags = f; pl_en = 1'b1;
        @(negedge clk);
        pl_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int t = 0; t < 200; t++) begin
            @(negedge clk);
            if (seen) begin
                if (busy) extra++;
                else break;
            end
            if (fl_cmd_valid && fl_done && fl_cmd == 2'd3 && fl_blk == 2'd2) seen = 1;
        end
    endtask

    task automatic wait_idle();
        for (int t = 0; t < 500; t++) begin
            @(negedge clk);
            if (!busy) break;
        end
    endtask

    task automatic do_update(input string tag);
        int old_c, tgt, e0, n0, d0;
        old_c = int'(cur_blk); tgt = ring_next(old_c);
        e0 = erase_cnt[tgt]; n0 = ncmd; d0 = ndata;
        seed = seed + 8'h5B;
        upd_req = 1'b1;
        @(negedge clk);
        upd_req = 1'b0;
        repeat (4) @(negedge clk);
        upd_req = 1'b1;           // dropped: busy (R10)
        @(negedge clk);
        upd_req = 1'b0;
        wait_idle();
        repeat (5) @(negedge clk);
        check(!busy, "R10 stays idle", int'(busy), 0);
        check(ncmd - n0 == WORDS + 2, "R10 single update", ncmd - n0, WORDS + 2);
        check(erase_cnt[tgt] == e0 + 1, {"R6 erase target ", tag}, erase_cnt[tgt] - e0, 1);
        check(ndata - d0 == WORDS, "R6 word count", ndata - d0, WORDS);
        for (int w = 0; w < WORDS; w++)
            check(mem[tgt][w] == (seed ^ (8'(w) * 8'd37)), "R6 data", int'(mem[tgt][w]),
                  int'(seed ^ (8'(w) * 8'd37)));
        check(mflag[old_c] == 1'b1, {"R7 old flag ", tag}, int'(mflag[old_c]), 1);
        check(mflag[tgt] == 1'b0, "R7 new flag blank", int'(mflag[tgt]), 0);
        check(int'(cur_blk) == tgt && cur_valid, {"R8 advance ", tag}, int'(cur_blk), tgt);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int extra, exp_blk, n0;
        bit exp_err, exp_val;
        @(negedge clk);
        check(busy && fl_cmd_valid && fl_cmd == 2'd3 && fl_blk == 2'd0,
              "R1 reset state", int'(fl_blk), 0);
        for (int p = 0; p < 8; p++) begin
            logic [2:0] f;
            f = 3'(p);
            exp_err = (f == 3'b111);
            exp_val = 1'b0; exp_blk = 2;
            for (int i = 0; i < 3; i++)
                if (!f[i] && f[(i + 2) % 3]) begin exp_val = 1'b1; exp_blk = i; end
            start_up(f, extra);
            check(rd_n == 3 && rd_log[0] == 2'd0 && rd_log[1] == 2'd1 && rd_log[2] == 2'd2,
                  "R1 read order", rd_n, 3);
            check(extra == 1, "R1 decode latency", extra, 1);
            if (exp_err) begin
                check(err && !busy, "R4 corrupt", int'(err), 1);
                n0 = ncmd;
                upd_req = 1'b1;
                @(negedge clk);
                upd_req = 1'b0;
                repeat (20) @(negedge clk);
                check(ncmd == n0 && !fl_cmd_valid, "R5 no command", ncmd - n0, 0);
                check(err, "R5 sticky", int'(err), 1);
            end else begin
                check(!err, "R2 no error", int'(err), 0);
                check(cur_valid == exp_val, f == 0 ? "R3 empty" : "R2 valid",
                      int'(cur_valid), int'(exp_val));
                check(int'(cur_blk) == exp_blk, f == 0 ? "R3 empty blk" : "R2 block",
                      int'(cur_blk), exp_blk);
                do_update(f == 0 ? "R3 first" : "a");
                do_update("b");
                do_update("c");
            end
        end

        // interruption during data writes: Y current (x programmed)
        start_up(3'b001, extra);
        check(int'(cur_blk) == 1, "R9 setup", int'(cur_blk), 1);
        upd_req = 1'b1;
        @(negedge clk);
        upd_req = 1'b0;
        for (int t = 0; t < 200; t++) begin
            @(negedge clk);
            if (fl_cmd_valid && fl_cmd == 2'd1 && fl_idx == 2'd1) break;
        end
        start_up(mflag, extra);
        check(int'(cur_blk) == 1 && cur_valid, "R9 mid-write", int'(cur_blk), 1);

        // interruption while the flag program is pending
        upd_req = 1'b1;
        @(negedge clk);
        upd_req = 1'b0;
        for (int t = 0; t < 200; t++) begin
            @(negedge clk);
            if (fl_cmd_valid && fl_cmd == 2'd2) break;
        end
        start_up(mflag, extra);
        check(int'(cur_blk) == 1 && cur_valid, "R9 pre-commit", int'(cur_blk), 1);
        do_update("after R9");

        check(hold_bad == 0, "R11 command hold", hold_bad, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule